// File: doc/BRIEF.md
# Smooth Cyclic Wraparound Activation Unit

This block turns a wide signed pre-activation, the exact sum of a dot product, into the value a periodic activation produces when the sum is held in a narrow `ACC_W`-bit accumulator that wraps on overflow. The first stage folds the input into the signed `ACC_W`-bit range. The folded value `m` is the input taken modulo `2^ACC_W` and centred on zero. The second stage applies a piecewise-linear shaping. Values near zero pass through unchanged. Near either end of the range the curve turns back with slope `-SLOPE`, so the output meets zero at the wrap point and the periodic curve has no jump.

A result is produced every cycle. Each accepted input appears at the output exactly two cycles later, and a valid flag travels with it. The slope `SLOPE` (k) is fixed at elaboration; its default is 2. Let H = 2^(ACC_W-1). The region tests multiply `m` by (k+1) and compare the product with ±k·H at full width, so no division is needed.

Top module: `smooth_wrap_act`

## Requirements
- R1: The output depends only on the input modulo 2^ACC_W. The folded value m is the low ACC_W bits of the input read as two's complement, so two inputs that differ by a multiple of 2^ACC_W give the same result.
- R2: When (k+1)·m lies strictly between −k·H and k·H, the output equals m.
- R3: When (k+1)·m > k·H, the output equals k·H − k·m. This value is non-negative and smaller than m.
- R4: When (k+1)·m < −k·H, the output equals −k·H − k·m. This value is non-positive and greater than m.
- R5: When (k+1)·m equals exactly +k·H or −k·H, the value is in the identity region and the output equals m. This case arises for k=1 at m=±64 with ACC_W=8.
- R6: out_valid is high exactly two clock cycles after an input cycle with in_valid high, and low otherwise.
- R7: While reset is asserted, and during the two-cycle release after it, out_valid is 0 and out_act is 0.
- R8: out_act changes only in a cycle in which out_valid is high. A cycle with in_valid low leaves the held result untouched.
- R9: For consecutive folded values m and m+1, including the wrap from H−1 to −H, the outputs differ by at most k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| in_valid | input | 1 | Marks in_z as a sample to process |
| in_z | input | IN_W | Signed wide pre-activation |
| out_valid | output | 1 | Marks out_act as a new result |
| out_act | output | ACC_W | Signed shaped activation |

## Verification
Checks run on every cycle for three things: the identity region and the sign and ordering bounds of both bent regions, taken from the registered value against the folded input one cycle earlier; the two-cycle valid alignment; and the rule that the result holds still between valid cycles. Only the bench scenarios can show the exact bent values, the equality case at each threshold, the equivalence of inputs that differ by whole periods, and the continuity across the wrap point. The bench shows these by sweeping every folded value for slopes 1, 2 and 4 against an independent integer model.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic [1:0] {
    REG_MID  = 2'd0,
    REG_HIGH = 2'd1,
    REG_LOW  = 2'd2
  } swa_region_e;
endpackage

// File: rtl/swa_rst_sync.sv
module swa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/swa_fold.sv
module swa_fold #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_z,
  output logic                    fold_valid,
  output logic signed [ACC_W-1:0] fold_m
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0]        shifted;
  logic signed [ACC_W-1:0] m_d;
  logic                    valid_q;
  logic signed [ACC_W-1:0] m_q;

  // add half a period, keep the low bits (the modulo), remove the offset
  always_comb begin
    shifted = in_z[ACC_W-1:0] + HALF;
    m_d     = $signed(shifted - HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      m_q     <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) m_q <= m_d;
    end
  end

  assign fold_valid = valid_q;
  assign fold_m     = m_q;
endmodule

// File: rtl/swa_bend.sv
module swa_bend
  import swa_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int SLOPE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [ACC_W-1:0] m_in,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] act_out
);
  localparam int WW    = ACC_W + $clog2(SLOPE + 2) + 2;
  localparam int THR_I = SLOPE * (1 << (ACC_W - 1));
  localparam logic signed [WW-1:0] THR = WW'(THR_I);
  localparam logic signed [WW-1:0] KS  = WW'(SLOPE);
  localparam logic signed [WW-1:0] K1  = WW'(SLOPE + 1);

  logic signed [WW-1:0]    m_ext;
  logic signed [WW-1:0]    m_scaled;
  logic signed [WW-1:0]    bent_hi;
  logic signed [WW-1:0]    bent_lo;
  swa_region_e             region;
  logic signed [ACC_W-1:0] act_d;
  logic                    valid_q;
  logic signed [ACC_W-1:0] act_q;

  always_comb begin
    m_ext    = WW'(m_in);
    m_scaled = m_ext * K1;
    bent_hi  = THR - m_ext * KS;
    bent_lo  = -THR - m_ext * KS;
    if (m_scaled > THR)       region = REG_HIGH;
    else if (m_scaled < -THR) region = REG_LOW;
    else                      region = REG_MID;
    unique case (region)
      REG_HIGH: act_d = bent_hi[ACC_W-1:0];
      REG_LOW:  act_d = bent_lo[ACC_W-1:0];
      default:  act_d = m_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      act_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) act_q <= act_d;
    end
  end

  assign out_valid = valid_q;
  assign act_out   = act_q;

  // R2: identity region passes m through
  p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && region == REG_MID) |=> (act_q == $past(m_in)));

  // R3: upper bend lands in [0, m)
  p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && region == REG_HIGH) |=>
      (act_q >= 0 && act_q < $past(m_in)));

  // R4: lower bend lands in (m, 0]
  p_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && region == REG_LOW) |=>
      (act_q <= 0 && act_q > $past(m_in)));

  // R8: result only moves together with a valid flag
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> valid_q);
endmodule

// File: rtl/smooth_wrap_act.sv
module smooth_wrap_act #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 8,
  parameter int SLOPE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_z,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_act
);
  localparam int SYNC_STAGES = 2;

  logic                    rst_q_n;
  logic                    s1_valid;
  logic signed [ACC_W-1:0] s1_m;

  swa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  swa_fold #(.IN_W(IN_W), .ACC_W(ACC_W)) u_fold (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .in_valid   (in_valid),
    .in_z       (in_z),
    .fold_valid (s1_valid),
    .fold_m     (s1_m)
  );

  swa_bend #(.ACC_W(ACC_W), .SLOPE(SLOPE)) u_bend (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .in_valid  (s1_valid),
    .m_in      (s1_m),
    .out_valid (out_valid),
    .act_out   (out_act)
  );

  // R6: each stage delays valid by exactly one cycle
  p_stage1_lat_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    s1_valid == $past(in_valid));

  p_stage2_lat_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == $past(s1_valid));
endmodule

// File: tb/sim_smooth_wrap_act.sv
module sim_smooth_wrap_act;
  localparam int IN_W  = 16;
  localparam int ACC_W = 8;
  localparam int HALF  = 1 << (ACC_W - 1);
  localparam int NV    = 18;
  // directed vectors for k = 2: input and expected output
  localparam int VZ [NV] = '{0, 85, 86, 127, 128, -85, -86, -128, -127,
                             300, -300, 1000, 32767, -32768, 200, 170, 383, 384};
  localparam int VE [NV] = '{0, 85, 84, 2, 0, -85, -84, 0, -2,
                             44, -44, -24, -1, 0, -56, -84, 2, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_z = '0;
  logic v2, v1, v4;
  logic signed [ACC_W-1:0] a2, a1, a4;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  smooth_wrap_act #(.IN_W(IN_W), .ACC_W(ACC_W), .SLOPE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z),
    .out_valid(v2), .out_act(a2));
  smooth_wrap_act #(.IN_W(IN_W), .ACC_W(ACC_W), .SLOPE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z),
    .out_valid(v1), .out_act(a1));
  smooth_wrap_act #(.IN_W(IN_W), .ACC_W(ACC_W), .SLOPE(4)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z),
    .out_valid(v4), .out_act(a4));

  function automatic int model(input int m, input int k);
    if ((k + 1) * m > k * HALF)       return k * HALF - k * m;
    else if ((k + 1) * m < -k * HALF) return -k * HALF - k * m;
    else                              return m;
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int p1, p2, p4, f1, f2, f4, held;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 valid in reset", int'(v2), 0);
    chk("R7 data in reset", int'(a2), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 valid during release", int'(v2), 0);
    repeat (3) @(negedge clk);

    // directed table, k = 2
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_z = IN_W'(VZ[i]);
      @(negedge clk);
      in_valid = 1'b0;
      in_z = IN_W'(-VZ[i] + 7);
      chk("R6 no early valid", int'(v2), 0);
      @(negedge clk);
      chk("R6 valid after two cycles", int'(v2), 1);
      chk("R1 R2 R3 R4 table value", int'(a2), VE[i]);
      held = int'(a2);
      @(negedge clk);
      chk("R6 valid single cycle", int'(v2), 0);
      chk("R8 result held", int'(a2), held);
    end

    // R5: threshold equality stays in identity region; next step bends
    in_valid = 1'b1; in_z = 16'sd64;
    @(negedge clk); in_z = 16'sd65;
    @(negedge clk); in_z = 16'sd102;
    chk("R5 k1 m=64", int'(a1), 64);
    @(negedge clk); in_z = 16'sd103;
    chk("R3 k1 m=65", int'(a1), 63);
    @(negedge clk); in_z = -16'sd64;
    chk("R5 k4 m=102", int'(a4), 102);
    @(negedge clk); in_valid = 1'b0;
    chk("R3 k4 m=103", int'(a4), 100);
    @(negedge clk);
    chk("R5 k1 m=-64", int'(a1), -64);
    @(negedge clk);

    // streamed sweep of every folded value, with whole-period offsets (R1)
    p1 = 0; p2 = 0; p4 = 0; f1 = 0; f2 = 0; f4 = 0;
    for (int i = 0; i < 2 * HALF + 2; i++) begin
      if (i < 2 * HALF) begin
        in_valid = 1'b1;
        in_z = IN_W'((i - HALF) + 2 * HALF * ((i % 7) - 3));
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (i >= 1 && i <= 2 * HALF) begin
        int m;
        m = i - 1 - HALF;
        chk("R6 sweep valid", int'(v2), 1);
        chk("R1 R2 R3 R4 sweep k2", int'(a2), model(m, 2));
        chk("R1 R2 R3 R4 sweep k1", int'(a1), model(m, 1));
        chk("R1 R2 R3 R4 sweep k4", int'(a4), model(m, 4));
        if (i == 1) begin
          f1 = int'(a1); f2 = int'(a2); f4 = int'(a4);
        end else begin
          chk("R9 step k1", int'(iabs(int'(a1) - p1) <= 1), 1);
          chk("R9 step k2", int'(iabs(int'(a2) - p2) <= 2), 1);
          chk("R9 step k4", int'(iabs(int'(a4) - p4) <= 4), 1);
        end
        p1 = int'(a1); p2 = int'(a2); p4 = int'(a4);
      end
    end
    // R9: wrap from H-1 back to -H
    chk("R9 wrap k1", int'(iabs(f1 - p1) <= 1), 1);
    chk("R9 wrap k2", int'(iabs(f2 - p2) <= 2), 1);
    chk("R9 wrap k4", int'(iabs(f4 - p4) <= 4), 1);
    chk("R6 idle after sweep", int'(v2), 0);

    // R7: reset mid-stream clears output
    in_valid = 1'b1; in_z = 16'sd50;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 reset clears valid", int'(v2), 0);
    chk("R7 reset clears data", int'(a2), 0);
    in_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule